// File: doc/BRIEF.md
# Overlay Window Clip-List Scanner

This block works out, pixel by pixel while a raster is being scanned, which of up to sixteen rectangular overlay windows cover the current position. It keeps no rectangle per window. Software prepares two sorted breakpoint lists, one for the vertical axis and one for the horizontal axis. Each list entry holds a coordinate and a vector of per-window display flags that apply from that coordinate onward. Software writes both lists into a small local word memory through a host write port.

During a frame, a line walker steps through the vertical list as the line counter reaches each breakpoint. A pixel walker restarts at every line start and steps through the horizontal list as the pixel counter reaches each breakpoint. The two latched flag vectors are ANDed and registered to give a per-window coverage mask and an "any overlay" flag. A downstream blender uses these outputs. Host writes are shut out while a frame is in progress, so the lists stay fixed for the whole frame.

Top module: `ovl_clip_scanner`

## Requirements
- R1: After reset, `cover_mask` and `any_cover` are 0.
- R2: Horizontal-list entry i is stored at word address 2i and vertical-list entry i at word address 2i+1. In each word, bits 10:0 hold the coordinate and bit 16+w holds the display flag of window w. Bits 15:11 are ignored.
- R3: Each list is walked over at most 16 entries. When all 16 are in use, no end entry is needed, and words beyond entry 15 are never applied.
- R4: A zero coordinate in entry 0 is a real breakpoint. A zero coordinate in any later entry ends that list, and the flags of that end entry are never applied.
- R5: `frame_start` clears the vertical flags and restarts the vertical walk at entry 0. On each `line_start` cycle, if `vcount` equals the next vertical entry's coordinate, the vertical flags take that entry's flags and the walk moves on. Otherwise the flags hold. A line start must come after the frame start, not in the same cycle.
- R6: On a `line_start` cycle the horizontal walk restarts at entry 0. If `hcount` in that cycle equals entry 0's coordinate, the horizontal flags take entry 0's flags; otherwise they clear. On every other cycle, if `hcount` equals the next horizontal entry's coordinate, the flags take that entry's flags and the walk moves on.
- R7: `cover_mask` bit w is the AND of the vertical and horizontal flags for window w. It appears two clock edges after the cycle that presented the counts.
- R8: `any_cover` is 1 exactly when `cover_mask` is nonzero, in the same cycle.
- R9: Host writes are ignored in the `frame_start` cycle and in every cycle up to and including the `frame_end` cycle. Writes at other times are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host write strobe for the list memory |
| host_wr_addr | input | 6 | Word address of the host write |
| host_wr_data | input | 32 | Word to write |
| hcount | input | 11 | Horizontal pixel counter |
| vcount | input | 11 | Vertical line counter |
| line_start | input | 1 | Strobe in the first pixel cycle of each line |
| frame_start | input | 1 | Strobe one cycle before the first line of a frame |
| frame_end | input | 1 | Strobe after the last pixel of a frame |
| cover_mask | output | 16 | Per-window coverage, registered |
| any_cover | output | 1 | High when any window covers |

## Verification
The assertions take the following as given:
- Each list is sorted in strictly ascending order.
- Each axis has at most sixteen distinct breakpoints.
- `line_start` never coincides with `frame_start`.
- `hcount` is 0 in the `line_start` cycle and rises by one per cycle.

The stimulus keeps within these rules. Window edges are drawn from a pool of sixteen evenly spaced values per axis, and the list builder in the bench emits each distinct edge once, in ascending order. The raster is driven as contiguous lines after a separate frame-start cycle. Unused memory words are filled with random data, so any read past an end entry or past entry 15 changes the mask.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
   localparam int unsigned ENTRY_W  = 32;
   localparam int unsigned FLAG_LSB = 16;
   typedef logic [ENTRY_W-1:0] ovl_word_t;
endpackage

// File: rtl/ovl_list_ram.sv
module ovl_list_ram
   import ovl_pkg::*;
#(
   parameter int unsigned DEPTH = 64,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic              wr_allow,
   input  logic [AW-1:0]     wr_addr,
   input  ovl_word_t         wr_data,
   input  logic [AW-1:0]     rd_addr_a,
   output ovl_word_t         rd_data_a,
   input  logic [AW-1:0]     rd_addr_b,
   output ovl_word_t         rd_data_b
);

   ovl_word_t mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_req && wr_allow) begin
         mem[wr_addr] <= wr_data;
      end
   end

   assign rd_data_a = mem[rd_addr_a];
   assign rd_data_b = mem[rd_addr_b];

   // a refused write must leave the addressed word untouched
   assert_blocked_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !wr_allow) |=> (mem[$past(wr_addr)] == $past(mem[wr_addr])))
      else $error("refused write changed the list memory");

endmodule

// File: rtl/ovl_list_walker.sv
module ovl_list_walker
   import ovl_pkg::*;
#(
   parameter int unsigned LIST_DEPTH    = 16,
   parameter int unsigned COORD_W       = 11,
   parameter int unsigned NUM_WIN       = 16,
   parameter bit          RESTART_MATCH = 1'b0,
   localparam int unsigned PW           = $clog2(LIST_DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               restart,
   input  logic               step,
   input  logic [COORD_W-1:0] count,
   output logic [PW-1:0]      entry_idx,
   input  logic [COORD_W-1:0] entry_coord,
   input  logic [NUM_WIN-1:0] entry_flags,
   output logic [NUM_WIN-1:0] flags
);

   logic [PW-1:0]      ptr_q;
   logic [NUM_WIN-1:0] flags_q;
   logic               at_end;
   logic               hit;

   // variant: the pixel walker compares entry 0 in the restart cycle itself
   generate
      if (RESTART_MATCH) begin : g_match_on_restart
         assign entry_idx = restart ? '0 : ptr_q;
      end else begin : g_plain_restart
         assign entry_idx = ptr_q;
      end
   endgenerate

   always_comb begin
      at_end = (ptr_q == PW'(LIST_DEPTH)) || ((ptr_q != '0) && (entry_coord == '0));
      hit    = (entry_coord == count);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q   <= '0;
         flags_q <= '0;
      end else if (restart) begin
         if (RESTART_MATCH && hit) begin
            ptr_q   <= PW'(1);
            flags_q <= entry_flags;
         end else begin
            ptr_q   <= '0;
            flags_q <= '0;
         end
      end else if (step && !at_end && hit) begin
         ptr_q   <= ptr_q + 1'b1;
         flags_q <= entry_flags;
      end
   end

   assign flags = flags_q;

   assert_ptr_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_q <= PW'(LIST_DEPTH))
      else $error("walk pointer ran past the list depth");

   assert_end_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart && at_end) |=> ($stable(flags_q) && $stable(ptr_q)))
      else $error("walker moved after reaching the list end");

   assert_single_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !restart |=> ((ptr_q == $past(ptr_q)) || (ptr_q == $past(ptr_q) + 1'b1)))
      else $error("walker skipped an entry");

endmodule

// File: rtl/ovl_clip_scanner.sv
module ovl_clip_scanner
   import ovl_pkg::*;
#(
   parameter int unsigned NUM_WIN    = 16,
   parameter int unsigned COORD_W    = 11,
   parameter int unsigned LIST_DEPTH = 16,
   parameter int unsigned MEM_DEPTH  = 64,
   localparam int unsigned MEM_AW    = $clog2(MEM_DEPTH),
   localparam int unsigned IDX_W     = $clog2(LIST_DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_wr_en,
   input  logic [MEM_AW-1:0]  host_wr_addr,
   input  logic [31:0]        host_wr_data,
   input  logic [COORD_W-1:0] hcount,
   input  logic [COORD_W-1:0] vcount,
   input  logic               line_start,
   input  logic               frame_start,
   input  logic               frame_end,
   output logic [NUM_WIN-1:0] cover_mask,
   output logic               any_cover
);

   localparam ovl_word_t USED_MASK = ENTRY_W'(((64'd1 << COORD_W) - 64'd1) |
                                     (((64'd1 << NUM_WIN) - 64'd1) << FLAG_LSB));

   // elaboration-time parameter checks
   generate
      if (COORD_W > FLAG_LSB) begin : g_bad_coord
         $error("coordinate field overlaps the flag field");
      end
      if (FLAG_LSB + NUM_WIN > ENTRY_W) begin : g_bad_win
         $error("too many windows for the entry word");
      end
      if (MEM_DEPTH < 2 * LIST_DEPTH + 2) begin : g_bad_depth
         $error("memory too small for two interleaved lists");
      end
   endgenerate

   logic                frame_active_q;
   logic                wr_allow;
   logic [IDX_W-1:0]    pix_idx, line_idx;
   logic [MEM_AW-1:0]   pix_addr, line_addr;
   ovl_word_t           pix_word, line_word;
   logic [NUM_WIN-1:0]  pix_flags, line_flags;
   logic [NUM_WIN-1:0]  cover_q;
   logic                any_q;
   logic                unused_reserved;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_active_q <= 1'b0;
      end else if (frame_start) begin
         frame_active_q <= 1'b1;
      end else if (frame_end) begin
         frame_active_q <= 1'b0;
      end
   end

   assign wr_allow = !(frame_start || frame_active_q);

   // horizontal list on even words, vertical list on odd words
   assign pix_addr  = MEM_AW'({pix_idx, 1'b0});
   assign line_addr = MEM_AW'({line_idx, 1'b1});

   ovl_list_ram #(.DEPTH(MEM_DEPTH)) u_ram (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_req    (host_wr_en),
      .wr_allow  (wr_allow),
      .wr_addr   (host_wr_addr),
      .wr_data   (host_wr_data),
      .rd_addr_a (pix_addr),
      .rd_data_a (pix_word),
      .rd_addr_b (line_addr),
      .rd_data_b (line_word)
   );

   assign unused_reserved = ^((pix_word | line_word) & ~USED_MASK);

   ovl_list_walker #(
      .LIST_DEPTH(LIST_DEPTH), .COORD_W(COORD_W), .NUM_WIN(NUM_WIN), .RESTART_MATCH(1'b0)
   ) u_line_walk (
      .clk         (clk),
      .rst_n       (rst_n),
      .restart     (frame_start),
      .step        (line_start),
      .count       (vcount),
      .entry_idx   (line_idx),
      .entry_coord (line_word[COORD_W-1:0]),
      .entry_flags (line_word[FLAG_LSB +: NUM_WIN]),
      .flags       (line_flags)
   );

   ovl_list_walker #(
      .LIST_DEPTH(LIST_DEPTH), .COORD_W(COORD_W), .NUM_WIN(NUM_WIN), .RESTART_MATCH(1'b1)
   ) u_pix_walk (
      .clk         (clk),
      .rst_n       (rst_n),
      .restart     (line_start),
      .step        (1'b1),
      .count       (hcount),
      .entry_idx   (pix_idx),
      .entry_coord (pix_word[COORD_W-1:0]),
      .entry_flags (pix_word[FLAG_LSB +: NUM_WIN]),
      .flags       (pix_flags)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cover_q <= '0;
         any_q   <= 1'b0;
      end else begin
         cover_q <= line_flags & pix_flags;
         any_q   <= |(line_flags & pix_flags);
      end
   end

   assign cover_mask = cover_q;
   assign any_cover  = any_q;

   assert_any_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
      any_cover == (cover_mask != '0))
      else $error("any_cover disagrees with cover_mask");

   assert_frame_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> !wr_allow)
      else $error("writes open right after frame start");

endmodule

// File: tb/tb_ovl_clip_scanner.sv
module tb_ovl_clip_scanner;
   localparam int NW = 16;
   localparam int AW = 6;
   localparam int RW = 48;
   localparam int RH = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_wr_en = 1'b0;
   logic [AW-1:0] host_wr_addr = '0;
   logic [31:0] host_wr_data = '0;
   logic [10:0] hcount = '0, vcount = '0;
   logic line_start = 1'b0, frame_start = 1'b0, frame_end = 1'b0;
   logic [NW-1:0] cover_mask;
   logic any_cover;

   always #10 clk = ~clk;

   ovl_clip_scanner dut (
      .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_wr_addr(host_wr_addr),
      .host_wr_data(host_wr_data), .hcount(hcount), .vcount(vcount),
      .line_start(line_start), .frame_start(frame_start), .frame_end(frame_end),
      .cover_mask(cover_mask), .any_cover(any_cover)
   );

   int checks = 0, errors = 0;
   bit done = 0;
   string cur_tag = "R7";
   int win_l[NW], win_r[NW], win_t[NW], win_b[NW];
   bit win_on[NW];

   int drv_v = 0, drv_h = 0; bit drv_vld = 0;
   int v1 = 0, h1 = 0, v2 = 0, h2 = 0; bit vld1 = 0, vld2 = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [NW-1:0] exp_mask(input int v, input int h);
      logic [NW-1:0] m = '0;
      for (int w = 0; w < NW; w++)
         if (win_on[w] && h >= win_l[w] && h < win_r[w] && v >= win_t[w] && v < win_b[w])
            m[w] = 1'b1;
      return m;
   endfunction

   always @(posedge clk) begin
      v2 <= v1; h2 <= h1; vld2 <= vld1;
      v1 <= drv_v; h1 <= drv_h; vld1 <= drv_vld;
   end

   always @(negedge clk) begin
      if (vld2 && rst_n) begin
         logic [NW-1:0] e;
         e = exp_mask(v2, h2);
         chk($sformatf("%s mask v=%0d h=%0d", cur_tag, v2, h2), 32'(cover_mask), 32'(e));
         chk($sformatf("R8 any v=%0d h=%0d", v2, h2), 32'(any_cover), 32'(e != '0));
      end
   end

   task automatic wr(input int a, input logic [31:0] d);
      host_wr_en = 1'b1; host_wr_addr = AW'(a); host_wr_data = d;
      @(posedge clk); #1;
      host_wr_en = 1'b0;
   endtask

   // builds one axis list (odd=1: vertical) from the window rectangles
   task automatic build_axis(input bit odd);
      int idx = 0;
      for (int c = 0; c < 64; c++) begin
         bit bp = 0;
         logic [NW-1:0] f = '0;
         for (int w = 0; w < NW; w++) begin
            int lo = odd ? win_t[w] : win_l[w];
            int hi = odd ? win_b[w] : win_r[w];
            if (win_on[w] && (lo == c || hi == c)) bp = 1;
            if (win_on[w] && lo <= c && c < hi) f[w] = 1'b1;
         end
         if (bp) begin
            wr(2 * idx + int'(odd), {f, 5'($urandom), 11'(c)});
            idx++;
         end
      end
      if (idx == 0) wr(int'(odd), {16'h0, 5'($urandom), 11'd0});
      else if (idx < 16) wr(2 * idx + int'(odd), {16'($urandom) | 16'h1, 5'($urandom), 11'd0});
   endtask

   task automatic load_lists();
      for (int a = 0; a < 64; a++) wr(a, $urandom | 32'h1);
      build_axis(1'b0);
      build_axis(1'b1);
   endtask

   task automatic rand_windows();
      int n = $urandom_range(1, NW);
      for (int w = 0; w < NW; w++) begin
         int a = $urandom_range(0, 14);
         int b = $urandom_range(a + 1, 15);
         int c = $urandom_range(0, 14);
         int d = $urandom_range(c + 1, 15);
         win_on[w] = (w < n); win_l[w] = 3 * a; win_r[w] = 3 * b;
         win_t[w] = 2 * c; win_b[w] = 2 * d;
      end
   endtask

   localparam logic [31:0] POISON = {16'hFFFF, 16'h0000};

   task automatic run_frame(input bit inject);
      frame_start = 1'b1;
      if (inject) begin host_wr_en = 1'b1; host_wr_addr = AW'(1); host_wr_data = POISON; end
      @(posedge clk); #1;
      frame_start = 1'b0; host_wr_en = 1'b0;
      for (int v = 0; v < RH; v++)
         for (int h = 0; h < RW; h++) begin
            line_start = (h == 0); hcount = 11'(h); vcount = 11'(v);
            drv_vld = 1; drv_v = v; drv_h = h;
            host_wr_en = inject && v == 5 && h == 10;
            host_wr_addr = '0; host_wr_data = POISON;
            @(posedge clk); #1;
         end
      drv_vld = 0; line_start = 1'b0; frame_end = 1'b1;
      host_wr_en = inject; host_wr_addr = '0; host_wr_data = POISON;
      @(posedge clk); #1;
      frame_end = 1'b0; host_wr_en = 1'b0;
      repeat (3) @(posedge clk);
      #1;
   endtask

   initial begin
      void'($urandom(32'd20240611));
      for (int w = 0; w < NW; w++) win_on[w] = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1 cover_mask after reset", 32'(cover_mask), 32'd0);
      chk("R1 any_cover after reset", 32'(any_cover), 32'd0);
      @(posedge clk); #1;

      // R3: both lists full, junk past entry 15 must not apply
      for (int w = 0; w < NW; w++) begin
         win_on[w] = (w < 8); win_l[w] = 6 * w; win_r[w] = 6 * w + 3;
         win_t[w] = 4 * w; win_b[w] = 4 * w + 2;
      end
      load_lists();
      wr(32, {16'hFFFF, 5'd0, 11'd47});
      wr(33, {16'hFFFF, 5'd0, 11'd31});
      cur_tag = "R3 full lists";
      run_frame(1'b0);

      // R9: writes during a frame are refused
      for (int w = 0; w < NW; w++) begin
         win_on[w] = (w == 0); win_l[w] = 6; win_r[w] = 12; win_t[w] = 4; win_b[w] = 10;
      end
      load_lists();
      cur_tag = "R9 writes in frame";
      run_frame(1'b1);
      cur_tag = "R9 next frame unchanged";
      run_frame(1'b0);
      // R9: an idle write is stored: poison entry 0 of both lists
      wr(0, POISON);
      wr(1, POISON);
      for (int w = 0; w < NW; w++) begin
         win_on[w] = 1; win_l[w] = 0; win_r[w] = 12; win_t[w] = 0; win_b[w] = 10;
      end
      cur_tag = "R9 idle write stored";
      run_frame(1'b0);

      // R2 R4 R5 R6 R7: random windows, random junk beyond the end entry
      for (int f = 0; f < 6; f++) begin
         rand_windows();
         load_lists();
         cur_tag = "R2 R4 R5 R6 R7 random";
         run_frame(1'b0);
      end

      // R4: window starting at coordinate 0 on both axes, short lists
      for (int w = 0; w < NW; w++) begin
         win_on[w] = (w < 2); win_l[w] = 0; win_r[w] = 9 + 9 * w;
         win_t[w] = 0; win_b[w] = 6 + 6 * w;
      end
      load_lists();
      cur_tag = "R4 zero first entry";
      run_frame(1'b0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule